// File: doc/BRIEF.md
# Board Control Register Block

A small memory-mapped peripheral for an evaluation board. It sits on a simple 32-bit register bus: address, write strobe, write data, read strobe and registered read data. It offers four read locations: a fixed board identification word, the board clock rate as a fixed constant, an LED register that software can write and read back, and a switch register. The switch register is the external switch inputs after a two-flop synchronizer.

A control location turns a software write into a system reset request. The block raises a one-cycle request pulse only when one exact magic value is written there. All other values are ignored. A reset sequencer elsewhere in the system acts on that pulse.

The block decodes a 64 KiB window. Only the word-address bits are used, so the low two address bits have no effect on any access.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at word offset 0x0 returns 0x09272011 on `bus_rdata` in the clock cycle after the cycle in which `bus_rd` is sampled high.
- R2: A read at word offset 0x4 returns the board clock rate 10000000 (0x00989680), with the same one-cycle read latency.
- R3: A write to offset 0x8 stores `bus_wdata` into the LED register. It appears on `led_o` in the cycle after the write, and a later read of 0x8 returns it. A read of 0x8 issued in the same cycle as a write to 0x8 returns the value held before that write.
- R4: A read at offset 0xC returns `sw_i` after two synchronizing flops. A change of `sw_i` first becomes readable by a read issued two cycles after the change is sampled; reads issued in the same cycle or one cycle later still return the old value.
- R5: A write of exactly 0x0000DEAD to offset 0x10 drives `sys_rst_req_o` high for exactly the one cycle after the write. A write of any other value to 0x10 leaves it low.
- R6: Reads at any offset other than 0x0, 0x4, 0x8 and 0xC return 0. Writes to offsets other than 0x8 and 0x10 change neither `led_o` nor `sys_rst_req_o`.
- R7: While `rst_n` is low, `led_o`, the switch register, `bus_rdata` and `sys_rst_req_o` are all zero. The switch register reads 0 on the first read after reset, whatever `sw_i` is.
- R8: Only address bits [15:2] are decoded. Accesses whose addresses differ only in bits [1:0] behave identically, for both reads and writes, including the reset-request write.
- R9: `bus_rdata` keeps its last value in every cycle that follows a cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address inside the 64 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| sw_i | input | 32 | Asynchronous switch inputs |
| led_o | output | 32 | LED register contents |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench writes near-miss values to the control location, such as 0xDEAE and 0x0001DEAD, and writes the magic value to the neighbouring offset. A decoder that compared only some of the data bits, or that decoded the address loosely, would raise a false reset request. It issues a read and a write of the LED register in the same cycle. A design that forwarded the write data would return the new value instead of the old one. It steps the switch inputs and reads them in the two cycles right after the change. A design with one synchronizer flop, or none, would show the new value too early. It also reads the switch register straight after reset with the inputs already set, which catches a register that does not clear. Accesses with nonzero low address bits, and to unmapped offsets, show whether a design decodes bits [1:0] or leaks stale data instead of zero.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] BOARD_ID_WORD = 32'h0927_2011;
  localparam logic [DATA_W-1:0] BOARD_CLK_HZ  = 32'd10_000_000;
  localparam logic [DATA_W-1:0] RST_MAGIC     = 32'h0000_DEAD;

  // word indices (byte offset / 4)
  localparam int WIDX_ID   = 0;
  localparam int WIDX_CLK  = 1;
  localparam int WIDX_LED  = 2;
  localparam int WIDX_SW   = 3;
  localparam int WIDX_RST  = 4;

  typedef enum logic [2:0] {
    SEL_ID,
    SEL_CLK,
    SEL_LED,
    SEL_SW,
    SEL_RST,
    SEL_NONE
  } reg_sel_e;

  // read data selected by a decoded location
  function automatic logic [DATA_W-1:0] read_word(
    input reg_sel_e          sel,
    input logic [DATA_W-1:0] led,
    input logic [DATA_W-1:0] sw
  );
    logic [DATA_W-1:0] r;
    case (sel)
      SEL_ID:  r = BOARD_ID_WORD;
      SEL_CLK: r = BOARD_CLK_HZ;
      SEL_LED: r = led;
      SEL_SW:  r = sw;
      default: r = '0;
    endcase
    return r;
  endfunction

  // true when a write carries the reset key
  function automatic logic is_reset_key(input logic [DATA_W-1:0] d);
    return d == RST_MAGIC;
  endfunction

endpackage

// File: rtl/board_ctl_sync.sv
module board_ctl_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             lsb_unused;

  assign widx       = addr_i[ADDR_W-1:2];
  assign lsb_unused = ^addr_i[1:0];

  always_comb begin
    case (widx)
      IDX_W'(WIDX_ID):  sel_o = SEL_ID;
      IDX_W'(WIDX_CLK): sel_o = SEL_CLK;
      IDX_W'(WIDX_LED): sel_o = SEL_LED;
      IDX_W'(WIDX_SW):  sel_o = SEL_SW;
      IDX_W'(WIDX_RST): sel_o = SEL_RST;
      default:          sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/board_ctl_rstreq.sv
module board_ctl_rstreq
  import board_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              key_match_o,
  output logic              pulse_o
);

  assign key_match_o = wr_hit_i && is_reset_key(wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= key_match_o;
  end

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SYNC_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] led_o,
  output logic              sys_rst_req_o
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] sw_sync;
  logic [DATA_W-1:0] led_q;
  logic [DATA_W-1:0] rdata_q;
  logic              led_wr_hit;
  logic              rst_wr_hit;
  logic              key_match;

  board_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  board_ctl_sync #(.W(DATA_W), .STAGES(SYNC_STEP)) u_sw_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sw_i),
    .q_o   (sw_sync)
  );

  assign led_wr_hit = bus_wr && (sel == SEL_LED);
  assign rst_wr_hit = bus_wr && (sel == SEL_RST);

  board_ctl_rstreq u_rstreq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hit_i    (rst_wr_hit),
    .wdata_i     (bus_wdata),
    .key_match_o (key_match),
    .pulse_o     (sys_rst_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          led_q <= '0;
    else if (led_wr_hit) led_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= read_word(sel, led_q, sw_sync);
  end

  assign led_o     = led_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] led_o,
  input logic              key_match,
  input logic              sys_rst_req_o
);

  logic [ADDR_W-3:0] widx;
  logic              mapped_rd;
  logic              magic_wr;

  assign widx      = bus_addr[ADDR_W-1:2];
  assign mapped_rd = (widx < (ADDR_W-2)'(4));
  assign magic_wr  = bus_wr && (widx == (ADDR_W-2)'(4)) && (bus_wdata == 32'h0000_DEAD);

  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx == 0) |=> bus_rdata == 32'h0927_2011); // R1

  AST_CLK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && widx == 1) |=> bus_rdata == 32'd10_000_000); // R2

  AST_LED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 2) |=> led_o == $past(bus_wdata)); // R3

  AST_LED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && widx == 2) |=> $stable(led_o)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped_rd) |=> bus_rdata == '0); // R6

  AST_RST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    magic_wr |=> sys_rst_req_o); // R5

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !key_match |=> !sys_rst_req_o); // R5

  AST_KEY_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    key_match |-> magic_wr); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

bind board_ctl_regs board_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .led_o         (led_o),
  .key_match     (key_match),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/test_board_ctl_regs.sv
module test_board_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] sw_i = '0;
  logic [31:0] led_o;
  logic        sys_rst_req_o;

  int checks = 0;
  int fails  = 0;
  logic rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  board_ctl_regs i_board_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sw_i(sw_i), .led_o(led_o), .sys_rst_req_o(sys_rst_req_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: a read sampled at a posedge is compared at the next negedge
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: read data with no expectation, got 0x%08h expected none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // called at a negedge; returns at the following negedge
  task automatic bus_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    sw_i = 32'h1357_9BDF;
    idle(3);
    check("R7 led in reset", led_o, 32'h0);
    check("R7 rdata in reset", bus_rdata, 32'h0);
    check("R7 rst_req in reset", {31'h0, sys_rst_req_o}, 32'h0);
    rst_n = 1'b1;
    bus_read(16'h000C, 32'h0, "R7 switch clear after reset");

    bus_read(16'h0000, 32'h0927_2011, "R1 id");
    bus_read(16'h0004, 32'd10_000_000, "R2 clock rate");
    bus_read(16'h0003, 32'h0927_2011, "R8 id with low bits");
    bus_read(16'h0006, 32'd10_000_000, "R8 clock rate with low bits");

    idle(2);
    check("R9 rdata held while idle", bus_rdata, 32'd10_000_000);

    bus_write(16'h0008, 32'hA5A5_5A5A);
    check("R3 led after write", led_o, 32'hA5A5_5A5A);
    bus_read(16'h0008, 32'hA5A5_5A5A, "R3 led readback");

    bus_addr = 16'h0008; bus_wdata = 32'h0F0F_1234; bus_wr = 1'b1; bus_rd = 1'b1;
    exp_q.push_back(32'hA5A5_5A5A); tag_q.push_back("R3 same-cycle read returns old");
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    bus_read(16'h0008, 32'h0F0F_1234, "R3 readback after overlap");

    bus_write(16'h000B, 32'h0000_1234);
    check("R8 led write with low bits", led_o, 32'h0000_1234);

    bus_write(16'h0000, 32'hFFFF_FFFF);
    check("R6 write to id ignored", led_o, 32'h0000_1234);
    bus_write(16'h0004, 32'hFFFF_FFFF);
    check("R6 write to clock ignored", led_o, 32'h0000_1234);
    bus_write(16'h000C, 32'h0000_DEAD);
    check("R6 write to switch ignored", led_o, 32'h0000_1234);
    check("R6 no reset from switch write", {31'h0, sys_rst_req_o}, 32'h0);
    bus_write(16'hFFFC, 32'h0000_DEAD);
    check("R6 write to top of window ignored", led_o, 32'h0000_1234);
    check("R6 no reset from top write", {31'h0, sys_rst_req_o}, 32'h0);

    bus_read(16'h0010, 32'h0, "R6 control reads zero");
    bus_read(16'h0014, 32'h0, "R6 unmapped 0x14");
    bus_read(16'h8000, 32'h0, "R6 unmapped 0x8000");
    bus_read(16'hFFFF, 32'h0, "R6 unmapped 0xFFFF");

    sw_i = 32'hCAFE_F00D;
    idle(3);
    bus_read(16'h000C, 32'hCAFE_F00D, "R4 switch value");
    sw_i = 32'h0000_00FF;
    bus_read(16'h000C, 32'hCAFE_F00D, "R4 same-cycle read is old");
    bus_read(16'h000C, 32'hCAFE_F00D, "R4 one cycle later still old");
    bus_read(16'h000C, 32'h0000_00FF, "R4 two cycles later new");

    bus_write(16'h0010, 32'h0000_DEAD);
    check("R5 reset pulse high", {31'h0, sys_rst_req_o}, 32'h1);
    idle(1);
    check("R5 reset pulse one cycle", {31'h0, sys_rst_req_o}, 32'h0);
    bus_write(16'h0010, 32'h0000_DEAE);
    check("R5 near value no pulse", {31'h0, sys_rst_req_o}, 32'h0);
    bus_write(16'h0010, 32'h0001_DEAD);
    check("R5 upper bits set no pulse", {31'h0, sys_rst_req_o}, 32'h0);
    bus_write(16'h0013, 32'h0000_DEAD);
    check("R8 reset key with low bits", {31'h0, sys_rst_req_o}, 32'h1);
    bus_write(16'h0014, 32'h0000_DEAD);
    check("R6 key at neighbour no pulse", {31'h0, sys_rst_req_o}, 32'h0);
    check("R6 led untouched by control writes", led_o, 32'h0000_1234);

    idle(3);
    check("R1 scoreboard drained", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule